// File: doc/BRIEF.md
# Key-Sequence Register Unlock Guard

This block guards two writable registers: a general control register and an option-control register. Each one comes out of reset locked. It can be opened only when software writes two fixed 32-bit magic values, in a fixed order, to that register's own key address. While a register is locked, writes to its fields are dropped, and the bus sees an error response on that access. Software can lock either register again at any time by writing 1 to its lock bit.

A key write that does not match the expected next value puts that path into a sticky lockout. This also covers a second key written without a valid first key, and any key written while the path is already open. The path stays locked, answers every later key write with a bus error, and ignores even a correct sequence. Only a reset clears the lockout. One set of option bytes serves every flash bank in the system, so a single option path sits here, next to the main control path. What the unlocked fields drive lies outside this block. Here they are plain storage, read back on the output buses.

Top module: `key_unlock_guard`

## Requirements
- R1: After reset both registers read as locked (bit 0 of each readback is 1), both stuck flags are 0, busErr and optStart are 0, and all stored fields are 0.
- R2: Writing 0x45670123 and then 0xCDEF89AB to address 0 (main key) clears bit 0 of ctrlReg. The change is visible after the clock edge that takes the second key, and neither write raises busErr.
- R3: Writing 0x08192A3B and then 0x4C5D6E7F to address 1 (option key) clears bit 0 of optCtrlReg, with the same timing and no busErr.
- R4: On either key address, any write other than the expected next key sets that path's stuck flag and keeps or forces its lock. This includes the second key arriving first and any key written while the path is open. The other path is unaffected.
- R5: Once a path is stuck, every later key write to it, correct sequences included, leaves it locked and raises busErr. Only reset clears the stuck flag.
- R6: A write to address 2 (control) while the main path is locked, or to address 3 (option control) while the option path is locked, changes no stored field and raises busErr.
- R7: A write to address 2 while the main path is open stores bits 31:1 into ctrlReg[31:1]. If bit 0 of the write is 1, the main path locks again and a new two-key sequence is needed to open it.
- R8: A write to address 3 while the option path is open stores bits 31:2 into optCtrlReg[31:2]. If bit 1 is 1, optStart pulses high for the one cycle after the write; bit 1 always reads back 0. If bit 0 is 1, the option path locks again.
- R9: busErr is high for exactly the one cycle after a faulting write and low otherwise. Accepted key writes and permitted register writes never raise it.
- R10: Writes to addresses other than 0 to 3 change nothing and raise no busErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one access per cycle |
| busAddr | input | ADDR_W (4) | Word address of the write |
| busWrData | input | 32 | Write data |
| busErr | output | 1 | Error response for the previous cycle's write |
| ctrlReg | output | 32 | Control register readback; bit 0 is the main lock |
| optCtrlReg | output | 32 | Option-control readback; bit 0 is the option lock, bit 1 reads 0 |
| optStart | output | 1 | One-cycle option commit pulse |
| mainStuck | output | 1 | Main path permanently locked until reset |
| optStuck | output | 1 | Option path permanently locked until reset |

## Verification
The assertions check, on every cycle, the invariants that do not depend on the data: a stuck path never leaves the stuck state and is always locked, a lock only opens right after a key write, a locked register's fields hold still, an optStart pulse follows only an open option path, and busErr never appears without a write or after an unmapped write. Other behaviour can only be shown by the bench's scenarios against its reference model. This covers whether the right key values in the right order open a path, whether a premature second key or a key written on an open path counts as wrong, whether a later correct sequence fails to revive a stuck path, and whether the two paths stay independent of each other.

// File: rtl/kug_pkg.sv
package kug_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_PATHS = 2;
  localparam int PATH_MAIN = 0;
  localparam int PATH_OPT  = 1;

  localparam logic [DATA_W-1:0] MAIN_KEY_A = 32'h4567_0123;
  localparam logic [DATA_W-1:0] MAIN_KEY_B = 32'hCDEF_89AB;
  localparam logic [DATA_W-1:0] OPT_KEY_A  = 32'h0819_2A3B;
  localparam logic [DATA_W-1:0] OPT_KEY_B  = 32'h4C5D_6E7F;

  // Word addresses: key of path p at p, guarded register of path p at 2+p.
  function automatic int keyAddr(input int p);
    return p;
  endfunction

  function automatic int regAddr(input int p);
    return NUM_PATHS + p;
  endfunction

  function automatic logic [DATA_W-1:0] firstKey(input int p);
    return (p == PATH_MAIN) ? MAIN_KEY_A : OPT_KEY_A;
  endfunction

  function automatic logic [DATA_W-1:0] secondKey(input int p);
    return (p == PATH_MAIN) ? MAIN_KEY_B : OPT_KEY_B;
  endfunction

  typedef struct packed {
    logic ctrlFieldWe;
    logic optFieldWe;
    logic optStartReq;
    logic errReq;
  } strobe_t;
endpackage

// File: rtl/kug_key_seq.sv
module kug_key_seq
  import kug_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_A = '0,
  parameter logic [DATA_W-1:0] KEY_B = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyWr,
  input  logic [DATA_W-1:0] keyData,
  input  logic              relockReq,
  output logic              locked,
  output logic              stuck,
  output logic              seqErr
);
  logic armed;
  logic keyMatchA;
  logic keyMatchB;

  assign keyMatchA = (keyData == KEY_A);
  assign keyMatchB = (keyData == KEY_B);

  always_comb begin
    seqErr = 1'b0;
    if (keyWr) begin
      if (stuck || !locked) seqErr = 1'b1;
      else if (!armed)      seqErr = !keyMatchA;
      else                  seqErr = !keyMatchB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked <= 1'b1;
      stuck  <= 1'b0;
      armed  <= 1'b0;
    end else if (keyWr) begin
      if (!stuck) begin
        if (!locked) begin
          stuck  <= 1'b1;
          locked <= 1'b1;
          armed  <= 1'b0;
        end else if (!armed) begin
          if (keyMatchA) armed <= 1'b1;
          else           stuck <= 1'b1;
        end else begin
          armed <= 1'b0;
          if (keyMatchB) locked <= 1'b0;
          else           stuck  <= 1'b1;
        end
      end
    end else if (relockReq) begin
      locked <= 1'b1;
      armed  <= 1'b0;
    end
  end

  a_r5_stuck_sticky: assert property (@(posedge clk) disable iff (!rstN)
    stuck |=> stuck) else $error("stuck flag dropped without reset");

  a_r4_stuck_keeps_locked: assert property (@(posedge clk) disable iff (!rstN)
    stuck |-> locked) else $error("stuck path is open");

  a_r2_open_only_by_key: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> ($past(keyWr) && !$past(stuck)))
    else $error("lock opened without a key write");

  a_r7_relock_takes: assert property (@(posedge clk) disable iff (!rstN)
    relockReq |=> locked) else $error("relock request ignored");
endmodule

// File: rtl/kug_ctrl.sv
module kug_ctrl
  import kug_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [NUM_PATHS-1:0] lockedOut,
  output logic [NUM_PATHS-1:0] stuckOut,
  output strobe_t           strb
);
  logic [NUM_PATHS-1:0] keyWr;
  logic [NUM_PATHS-1:0] regHit;
  logic [NUM_PATHS-1:0] relockReq;
  logic [NUM_PATHS-1:0] seqErr;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    assign keyWr[p]     = wrEn && (wrAddr == ADDR_W'(keyAddr(p)));
    assign regHit[p]    = wrEn && (wrAddr == ADDR_W'(regAddr(p)));
    assign relockReq[p] = regHit[p] && !lockedOut[p] && wrData[0];

    kug_key_seq #(
      .KEY_A(firstKey(p)),
      .KEY_B(secondKey(p))
    ) u_seq (
      .clk      (clk),
      .rstN     (rstN),
      .keyWr    (keyWr[p]),
      .keyData  (wrData),
      .relockReq(relockReq[p]),
      .locked   (lockedOut[p]),
      .stuck    (stuckOut[p]),
      .seqErr   (seqErr[p])
    );
  end

  always_comb begin
    strb.ctrlFieldWe = regHit[PATH_MAIN] && !lockedOut[PATH_MAIN];
    strb.optFieldWe  = regHit[PATH_OPT]  && !lockedOut[PATH_OPT];
    strb.optStartReq = strb.optFieldWe && wrData[1];
    strb.errReq      = (|seqErr) || (|(regHit & lockedOut));
  end

  a_r4_one_path_per_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({keyWr, regHit})) else $error("write decoded to two targets");
endmodule

// File: rtl/kug_datapath.sv
module kug_datapath
  import kug_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [DATA_W-1:1]    fieldData,
  input  logic [NUM_PATHS-1:0] lockedIn,
  output logic [DATA_W-1:0]    ctrlReg,
  output logic [DATA_W-1:0]    optCtrlReg,
  output logic                 optStart,
  output logic                 busErr
);
  logic [DATA_W-1:1] ctrlField;
  logic [DATA_W-1:2] optField;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlField <= '0;
      optField  <= '0;
      optStart  <= 1'b0;
      busErr    <= 1'b0;
    end else begin
      if (strb.ctrlFieldWe) ctrlField <= fieldData;
      if (strb.optFieldWe)  optField  <= fieldData[DATA_W-1:2];
      optStart <= strb.optStartReq;
      busErr   <= strb.errReq;
    end
  end

  assign ctrlReg    = {ctrlField, lockedIn[PATH_MAIN]};
  assign optCtrlReg = {optField, 1'b0, lockedIn[PATH_OPT]};

  a_r6_ctrl_frozen: assert property (@(posedge clk) disable iff (!rstN)
    $past(lockedIn[PATH_MAIN]) |-> $stable(ctrlField))
    else $error("control field moved while locked");

  a_r6_opt_frozen: assert property (@(posedge clk) disable iff (!rstN)
    $past(lockedIn[PATH_OPT]) |-> $stable(optField))
    else $error("option field moved while locked");

  a_r8_start_needs_open: assert property (@(posedge clk) disable iff (!rstN)
    optStart |-> !$past(lockedIn[PATH_OPT]))
    else $error("commit pulse from a locked option path");
endmodule

// File: rtl/key_unlock_guard.sv
module key_unlock_guard
  import kug_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic              busErr,
  output logic [31:0]       ctrlReg,
  output logic [31:0]       optCtrlReg,
  output logic              optStart,
  output logic              mainStuck,
  output logic              optStuck
);
  localparam int MAPPED = 2 * NUM_PATHS;

  logic [NUM_PATHS-1:0] lockedBits;
  logic [NUM_PATHS-1:0] stuckBits;
  strobe_t              strb;

  kug_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (busWrEn),
    .wrAddr   (busAddr),
    .wrData   (busWrData),
    .lockedOut(lockedBits),
    .stuckOut (stuckBits),
    .strb     (strb)
  );

  kug_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .fieldData (busWrData[DATA_W-1:1]),
    .lockedIn  (lockedBits),
    .ctrlReg   (ctrlReg),
    .optCtrlReg(optCtrlReg),
    .optStart  (optStart),
    .busErr    (busErr)
  );

  assign mainStuck = stuckBits[PATH_MAIN];
  assign optStuck  = stuckBits[PATH_OPT];

  a_r9_err_after_write: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busWrEn)) else $error("error without a write");

  a_r10_unmapped_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (int'(busAddr) >= MAPPED)) |=> !busErr)
    else $error("error on unmapped address");
endmodule

// File: tb/key_unlock_guard_bench.sv
module key_unlock_guard_bench;
  localparam logic [31:0] MK1 = 32'h4567_0123;
  localparam logic [31:0] MK2 = 32'hCDEF_89AB;
  localparam logic [31:0] OK1 = 32'h0819_2A3B;
  localparam logic [31:0] OK2 = 32'h4C5D_6E7F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busErr, optStart, mainStuck, optStuck;
  logic [31:0] ctrlReg, optCtrlReg;

  int checkCnt = 0;
  int failCnt  = 0;

  // reference model
  bit [1:0]  mLock, mStuck, mArm;
  bit [31:1] mCtrl;
  bit [31:2] mOpt;
  bit        eErr, eStart;

  always #10 clk = ~clk;

  key_unlock_guard u_key_unlock_guard (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busErr(busErr), .ctrlReg(ctrlReg),
    .optCtrlReg(optCtrlReg), .optStart(optStart),
    .mainStuck(mainStuck), .optStuck(optStuck)
  );

  function automatic logic [31:0] keyOf(input int p, input int n);
    if (p == 0) return (n == 0) ? MK1 : MK2;
    return (n == 0) ? OK1 : OK2;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " ctrlReg"}, ctrlReg, {mCtrl, mLock[0]});
    check({tag, " optCtrlReg"}, optCtrlReg, {mOpt, 1'b0, mLock[1]});
    check({tag, " busErr R9"}, {31'd0, busErr}, {31'd0, eErr});
    check({tag, " optStart R8"}, {31'd0, optStart}, {31'd0, eStart});
    check({tag, " stuck R5"}, {30'd0, optStuck, mainStuck}, {30'd0, mStuck});
  endtask

  task automatic modelReset();
    mLock = 2'b11; mStuck = 2'b00; mArm = 2'b00;
    mCtrl = '0; mOpt = '0; eErr = 1'b0; eStart = 1'b0;
  endtask

  task automatic modelWrite(input logic [3:0] a, input logic [31:0] d);
    eErr = 1'b0; eStart = 1'b0;
    if (a < 4'd2) begin
      int p = int'(a);
      if (mStuck[p]) eErr = 1'b1;
      else if (!mLock[p]) begin
        mStuck[p] = 1'b1; mLock[p] = 1'b1; mArm[p] = 1'b0; eErr = 1'b1;
      end else if (!mArm[p]) begin
        if (d == keyOf(p, 0)) mArm[p] = 1'b1;
        else begin mStuck[p] = 1'b1; eErr = 1'b1; end
      end else begin
        mArm[p] = 1'b0;
        if (d == keyOf(p, 1)) mLock[p] = 1'b0;
        else begin mStuck[p] = 1'b1; eErr = 1'b1; end
      end
    end else if (a == 4'd2) begin
      if (mLock[0]) eErr = 1'b1;
      else begin
        mCtrl = d[31:1];
        if (d[0]) begin mLock[0] = 1'b1; mArm[0] = 1'b0; end
      end
    end else if (a == 4'd3) begin
      if (mLock[1]) eErr = 1'b1;
      else begin
        mOpt = d[31:2]; eStart = d[1];
        if (d[0]) begin mLock[1] = 1'b1; mArm[1] = 1'b0; end
      end
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs settled
  task automatic busWrite(input logic [3:0] a, input logic [31:0] d, input string tag);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
    modelWrite(a, d);
    checkAll(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    eErr = 1'b0; eStart = 1'b0;
    checkAll(tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    modelReset();
    @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd9137);
    doReset();
    checkAll("R1 reset");

    // R2: main unlock and field write, relock via bit 0 (R7)
    busWrite(4'd0, MK1, "R2 key1");
    busWrite(4'd0, MK2, "R2 key2");
    busWrite(4'd2, 32'hA5A5_0002, "R7 store");
    busWrite(4'd2, 32'h1234_5679, "R7 relock");
    busWrite(4'd2, 32'hFFFF_FFFE, "R6 locked ctrl");
    idle("R9 idle");
    busWrite(4'd0, MK1, "R7 rekey1");
    busWrite(4'd0, MK2, "R7 rekey2");

    // R3 and R8: option path
    busWrite(4'd3, 32'h0000_00F2, "R6 locked opt");
    busWrite(4'd1, OK1, "R3 key1");
    busWrite(4'd1, OK2, "R3 key2");
    busWrite(4'd3, 32'hC000_0006, "R8 start");
    idle("R8 pulse end");
    busWrite(4'd3, 32'h0000_0011, "R8 relock");

    // R10: unmapped addresses
    busWrite(4'd7, 32'hFFFF_FFFF, "R10 unmapped");
    busWrite(4'd15, MK1, "R10 unmapped key");

    // R4: key written while open, then R5 correct sequence fails
    busWrite(4'd0, MK1, "R4 key on open path");
    busWrite(4'd0, MK1, "R5 stuck key1");
    busWrite(4'd0, MK2, "R5 stuck key2");
    busWrite(4'd2, 32'h0000_0100, "R5 stuck ctrl");

    // R4: second key first, and 0xFFFFFFFF, on the option path
    doReset();
    checkAll("R1 reset again");
    busWrite(4'd1, OK2, "R4 key2 first");
    busWrite(4'd1, OK1, "R5 opt stuck key1");
    busWrite(4'd1, OK2, "R5 opt stuck key2");
    busWrite(4'd0, MK1, "R4 other path key1");
    busWrite(4'd0, MK2, "R4 other path key2");
    doReset();
    busWrite(4'd1, OK1, "R4 key1");
    busWrite(4'd1, 32'hFFFF_FFFF, "R4 bad key2");
    busWrite(4'd1, MK1, "R4 cross key");

    // constrained random
    doReset();
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      logic [3:0]  a;
      logic [31:0] d;
      if (i % 150 == 149) doReset();
      r = $urandom % 16;
      a = 4'($urandom % 5);
      if (a == 4'd4) a = 4'($urandom % 16);
      d = $urandom;
      if (a < 4'd2) begin
        if (r < 6)       d = keyOf(int'(a), 0);
        else if (r < 12) d = keyOf(int'(a), 1);
      end else if (r < 10) begin
        d[0] = 1'b0;
      end
      busWrite(a, d, "R4 random");
    end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule